// File: doc/BRIEF.md
# D-Channel Contention and Retry Controller

This block decides when a node may drive a shared D channel on a time-division line bus. It also decides what happens when two nodes collide. The physical-layer device reports the channel condition through one status bit in the command/indicate field. A separate extractor delivers that bit to the controller as a strobe and a value, once per bus frame. A value of 0 means the channel is free. A value of 1 means the channel is busy, or that a collision has occurred. Once a frame has been handed over, the controller waits for a "free" sample before it sends any bit. It then pulls bytes from a frame buffer, starting at the frame's base address, and presents them one bit at a time to the D-channel serializer.

If a collision is reported while the frame is still early, the controller rewinds and waits for the channel to be free again. Early means the byte now on the line lies within the first two buffers, where a buffer is `BUF_BYTES` bytes long. During the abort the line is held at the idle level 1. The read pointer goes back to the frame base, and the frame is then sent again in full. A collision reported later than that drops the frame. The controller then raises a sticky error flag and a one-cycle interrupt pulse.

Top module: `dchan_retry_ctrl`

## Requirements
- R1: Out of reset the controller is not busy, presents the idle level 1 on `txd_o` with `txd_en_o` low, makes no read request, and has `err_o`, `irq_o` and `done_o` low.
- R2: A `start_i` pulse while idle captures `frame_base_i` and `frame_len_i`. No bit is presented until an indicator strobe with value 0 (free) has been seen. Strobes with value 1 keep the controller waiting.
- R3: Bytes are read from the base address upward, one request at a time. Each byte is presented most significant bit first. `txd_en_o` is high while a bit is presented, and `bit_stb_i` advances to the next bit.
- R4: An indicator strobe with value 1 during transmission, while the byte on the line has zero-based index below 2*`BUF_BYTES`, aborts the frame. The line returns to 1 with `txd_en_o` low. The next read after a later free sample is at the frame base, and the whole frame is sent again.
- R5: Such a strobe at byte index 2*`BUF_BYTES` or later drops the frame. The controller returns to idle, `err_o` is set and stays set, `irq_o` pulses for exactly one cycle, and `done_o` does not pulse.
- R6: After the last bit of the last byte has been consumed, `done_o` pulses for one cycle and the controller returns to idle.
- R7: `err_clr_i` clears the sticky error. Indicator strobes while idle change nothing.
- R8: A frame that collides more than once within the retry window is restarted each time and completes intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new frame (accepted only when idle) |
| frame_base_i | input | ADDR_W | Buffer address of the first frame byte |
| frame_len_i | input | LEN_W | Frame length in bytes |
| rd_req_o | output | 1 | One-cycle byte read request |
| rd_addr_o | output | ADDR_W | Address of the requested byte |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read data byte |
| ind_stb_i | input | 1 | Indicator bit strobe, once per bus frame |
| ind_val_i | input | 1 | Indicator value: 0 free, 1 busy or collision |
| bit_stb_i | input | 1 | Serializer consumes the presented bit |
| txd_o | output | 1 | D-channel bit presented to the serializer |
| txd_en_o | output | 1 | A valid data bit is presented |
| busy_o | output | 1 | A frame is being handled |
| done_o | output | 1 | One-cycle pulse when a frame has completed |
| err_o | output | 1 | Sticky late-collision error |
| irq_o | output | 1 | One-cycle pulse on a late collision |
| err_clr_i | input | 1 | Clear the sticky error |

## Verification
The bench sweeps every frame length from one to seven bytes with a two-byte buffer size, and injects a collision at every possible byte position, including the boundary between the last retried byte and the first dropped one. An off-by-one in the window compare would turn a retry into a drop or a drop into a retry at byte index 3 or 4. A missing pointer rewind would show up as a restarted frame that begins at a later byte. Busy strobes are sent both before the first free sample and between retries; a controller that started on any strobe would emit bits too early. Double collisions check that the window counter resets on every abort. The bench also compares every emitted bit against the buffer pattern, so a bit-order or fetch-order mistake shows up as corrupted data.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BITC_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_FREE = 3'd1,
        ST_SEND      = 3'd2,
        ST_ABORT     = 3'd3,
        ST_DONE      = 3'd4
    } ctl_state_e;
endpackage

// File: rtl/dcr_ind_sampler.sv
module dcr_ind_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic val_i,
    output logic free_o,
    output logic coll_o
);
    typedef struct packed {
        logic free;
        logic coll;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = '0;
        smp_d.free = stb_i && !val_i;
        smp_d.coll = stb_i && val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign free_o = smp_q.free;
    assign coll_o = smp_q.coll;

    assert_evt_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({free_o, coll_o}));
endmodule

// File: rtl/dcr_shifter.sv
module dcr_shifter
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              adv_i,
    input  logic              flush_i,
    output logic              bit_o,
    output logic              empty_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] sr;
        logic [BITC_W-1:0] left;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (adv_i && shf_q.left != '0) begin
            shf_d.sr   = {shf_q.sr[BYTE_W-2:0], 1'b0};
            shf_d.left = shf_q.left - 1'b1;
        end
        if (load_i) begin
            shf_d.sr   = data_i;
            shf_d.left = BITC_W'(BYTE_W);
        end
        if (flush_i) begin
            shf_d.left = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign bit_o   = shf_q.sr[BYTE_W-1];
    assign empty_o = (shf_q.left == '0);

    // a byte is only loaded into an exhausted register
    assert_load_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> empty_o);
    assert_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);
endmodule

// File: rtl/dcr_fetch.sv
module dcr_fetch #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              rewind_i,
    input  logic              active_i,
    input  logic              need_i,
    input  logic              rd_valid_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              load_o,
    output logic [LEN_W-1:0]  cnt_o,
    output logic              all_fetched_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ptr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic              pend;
        logic              disc;
    } fch_t;

    fch_t fch_d, fch_q;

    always_comb begin
        fch_d    = fch_q;
        rd_req_o = active_i && need_i && !fch_q.pend && (fch_q.cnt != fch_q.len);
        load_o   = rd_valid_i && fch_q.pend && !fch_q.disc && active_i;

        if (rd_req_o) fch_d.pend = 1'b1;
        if (rd_valid_i) begin
            fch_d.pend = 1'b0;
            fch_d.disc = 1'b0;
        end
        if (load_o) begin
            fch_d.ptr = fch_q.ptr + 1'b1;
            fch_d.cnt = fch_q.cnt + 1'b1;
        end
        if (rewind_i) begin
            fch_d.ptr  = fch_q.base;
            fch_d.cnt  = '0;
            fch_d.disc = fch_d.pend;
        end
        if (init_i) begin
            fch_d.base = base_i;
            fch_d.ptr  = base_i;
            fch_d.len  = len_i;
            fch_d.cnt  = '0;
            fch_d.disc = fch_d.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fch_q <= '0;
        else        fch_q <= fch_d;
    end

    assign rd_addr_o     = fch_q.ptr;
    assign cnt_o         = fch_q.cnt;
    assign all_fetched_o = (fch_q.cnt == fch_q.len) && !fch_q.pend;

    assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);
    assert_rewind_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind_i && !init_i) |=> (rd_addr_o == fch_q.base) && (cnt_o == '0));
endmodule

// File: rtl/dchan_retry_ctrl.sv
module dchan_retry_ctrl
    import dcr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned LEN_W     = 8,
    parameter int unsigned BUF_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] frame_base_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    input  logic              ind_stb_i,
    input  logic              ind_val_i,
    input  logic              bit_stb_i,
    output logic              txd_o,
    output logic              txd_en_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              irq_o,
    input  logic              err_clr_i
);
    localparam logic [LEN_W:0] RETRY_LIM = (LEN_W+1)'(2 * BUF_BYTES);

    typedef struct packed {
        ctl_state_e st;
        logic       err;
        logic       irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             free_evt, coll_evt;
    logic             sh_bit, sh_empty, sh_adv;
    logic             f_load, f_all;
    logic [LEN_W-1:0] f_cnt;
    logic             init_c, drop_c, rewind_c, active_c, in_window;

    dcr_ind_sampler u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (ind_stb_i),
        .val_i  (ind_val_i),
        .free_o (free_evt),
        .coll_o (coll_evt)
    );

    dcr_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .init_i        (init_c),
        .base_i        (frame_base_i),
        .len_i         (frame_len_i),
        .rewind_i      (rewind_c),
        .active_i      (active_c),
        .need_i        (sh_empty),
        .rd_valid_i    (rd_valid_i),
        .rd_req_o      (rd_req_o),
        .rd_addr_o     (rd_addr_o),
        .load_o        (f_load),
        .cnt_o         (f_cnt),
        .all_fetched_o (f_all)
    );

    dcr_shifter u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (f_load),
        .data_i  (rd_data_i),
        .adv_i   (sh_adv),
        .flush_i (rewind_c),
        .bit_o   (sh_bit),
        .empty_o (sh_empty)
    );

    // byte on the line has index cnt-1 (or 0 before the first load)
    assign in_window = ({1'b0, f_cnt} <= RETRY_LIM);
    assign active_c  = (ctl_q.st == ST_SEND);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = 1'b0;
        init_c    = 1'b0;
        drop_c    = 1'b0;
        if (err_clr_i) ctl_d.err = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    init_c   = 1'b1;
                    ctl_d.st = ST_WAIT_FREE;
                end
            end
            ST_WAIT_FREE: begin
                if (free_evt) ctl_d.st = ST_SEND;
            end
            ST_SEND: begin
                if (coll_evt) begin
                    if (in_window) begin
                        ctl_d.st = ST_ABORT;
                    end else begin
                        drop_c    = 1'b1;
                        ctl_d.err = 1'b1;
                        ctl_d.irq = 1'b1;
                        ctl_d.st  = ST_IDLE;
                    end
                end else if (f_all && sh_empty) begin
                    ctl_d.st = ST_DONE;
                end
            end
            ST_ABORT: ctl_d.st = ST_WAIT_FREE;
            ST_DONE:  ctl_d.st = ST_IDLE;
            default:  ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, err: 1'b0, irq: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign rewind_c = (ctl_q.st == ST_ABORT) || drop_c;
    assign txd_en_o = active_c && !sh_empty;
    assign txd_o    = txd_en_o ? sh_bit : 1'b1;
    assign sh_adv   = bit_stb_i && txd_en_o;
    assign busy_o   = (ctl_q.st != ST_IDLE);
    assign done_o   = (ctl_q.st == ST_DONE);
    assign err_o    = ctl_q.err;
    assign irq_o    = ctl_q.irq;

    assert_wait_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT_FREE && !free_evt) |=> (ctl_q.st != ST_SEND));
    assert_abort_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SEND && coll_evt && in_window) |=> (txd_o && !txd_en_o && busy_o));
    assert_late_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SEND && coll_evt && !in_window) |=> (!busy_o && err_o && irq_o));
    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !err_clr_i) |=> err_o);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !(ctl_q.st == ST_SEND && coll_evt)) |=> !err_o);
endmodule

// File: tb/tb_dchan_retry_ctrl.sv
module tb_dchan_retry_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 4;
    localparam int BUF_BYTES = 2;
    localparam int WINDOW = 2 * BUF_BYTES;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [ADDR_W-1:0] frame_base_i = '0;
    logic [LEN_W-1:0]  frame_len_i = '0;
    logic rd_req_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic rd_valid_i = 1'b0;
    logic [7:0] rd_data_i = '0;
    logic ind_stb_i = 1'b0, ind_val_i = 1'b0, bit_stb_i = 1'b0;
    logic txd_o, txd_en_o, busy_o, done_o, err_o, irq_o;
    logic err_clr_i = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dchan_retry_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_base_i(frame_base_i),
        .frame_len_i(frame_len_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .ind_stb_i(ind_stb_i),
        .ind_val_i(ind_val_i), .bit_stb_i(bit_stb_i), .txd_o(txd_o), .txd_en_o(txd_en_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .irq_o(irq_o), .err_clr_i(err_clr_i)
    );

    int checks = 0, fails = 0, cyc = 0;
    int irq_cnt = 0, done_cnt = 0, req_n = 0;
    logic [ADDR_W-1:0] req_log [0:2047];
    logic mem_pend = 1'b0;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic rec [0:127];
    bit finished = 1'b0;

    function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
        return 8'(a * 8'd29 + 8'd71);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // buffer model: one-cycle read latency, logs every requested address
    always @(negedge clk) begin
        rd_valid_i <= 1'b0;
        if (mem_pend) begin
            rd_valid_i <= 1'b1;
            rd_data_i  <= pat(mem_addr);
            mem_pend   <= 1'b0;
        end
        if (rd_req_o) begin
            mem_pend <= 1'b1;
            mem_addr <= rd_addr_o;
            req_log[req_n % 2048] <= rd_addr_o;
            req_n <= req_n + 1;
        end
    end

    always @(negedge clk) begin
        if (irq_o) irq_cnt++;
        if (done_o) done_cnt++;
        cyc++;
        if (cyc > WD_LIMIT && !finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic ind_pulse(input logic v);
        ind_stb_i = 1'b1;
        ind_val_i = v;
        @(negedge clk);
        ind_stb_i = 1'b0;
        ind_val_i = 1'b0;
    endtask

    task automatic run_frame(input int len, input int k1, input int k2);
        logic [ADDR_W-1:0] base;
        int bits, attempt, kk, irq0, done0, restart_idx, exp_att, mism, guard;
        bit dropped, exp_drop, err0;
        base = ADDR_W'(len * 20 + (k1 + 1) * 3 + (k2 + 1));
        irq0 = irq_cnt; done0 = done_cnt; err0 = err_o;
        exp_att = 0; exp_drop = 1'b0;
        if (k1 >= 0) begin
            if (k1 < WINDOW) begin
                exp_att = 1;
                if (k2 >= 0) begin
                    if (k2 < WINDOW) exp_att = 2; else exp_drop = 1'b1;
                end
            end else exp_drop = 1'b1;
        end
        frame_base_i = base;
        frame_len_i = LEN_W'(len);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !txd_en_o, "R2 busy, silent before free", int'(txd_en_o), 0);
        ind_pulse(1'b1);
        repeat (3) @(negedge clk);
        chk(!txd_en_o && txd_o, "R2 busy sample keeps waiting", int'(txd_en_o), 0);
        restart_idx = req_n;
        ind_pulse(1'b0);
        bits = 0; attempt = 0; dropped = 1'b0; guard = 0;
        while (busy_o && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (bit_stb_i) begin
                bit_stb_i = 1'b0;
                continue;
            end
            kk = (attempt == 0) ? k1 : ((attempt == 1) ? k2 : -1);
            if (kk >= 0 && bits == kk * 8 && txd_en_o) begin
                ind_pulse(1'b1);
                repeat (2) @(negedge clk);
                if (kk < WINDOW) begin
                    chk(busy_o && !txd_en_o && txd_o, "R4 abort idles line", int'(txd_o), 1);
                    chk(err_o == err0, "R4 no error on retry", int'(err_o), int'(err0));
                    attempt++;
                    bits = 0;
                    ind_pulse(1'b1);
                    repeat (3) @(negedge clk);
                    chk(!txd_en_o, "R8 wait after abort", int'(txd_en_o), 0);
                    restart_idx = req_n;
                    ind_pulse(1'b0);
                end else begin
                    chk(!busy_o && err_o, "R5 late collision drops", int'(busy_o), 0);
                    dropped = 1'b1;
                    break;
                end
            end else if (txd_en_o) begin
                rec[bits] = txd_o;
                bit_stb_i = 1'b1;
                bits++;
            end
        end
        bit_stb_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(dropped == exp_drop, "R5 drop decision", int'(dropped), int'(exp_drop));
        if (dropped) begin
            chk(irq_cnt == irq0 + 1, "R5 single irq pulse", irq_cnt - irq0, 1);
            chk(done_cnt == done0, "R5 no done on drop", done_cnt - done0, 0);
            chk(err_o, "R5 error sticky", int'(err_o), 1);
        end else begin
            chk(done_cnt == done0 + 1, "R6 one done pulse", done_cnt - done0, 1);
            chk(!busy_o, "R6 idle after done", int'(busy_o), 0);
            chk(bits == len * 8, "R3 bit count", bits, len * 8);
            chk(attempt == exp_att, "R8 retry count", attempt, exp_att);
            mism = 0;
            for (int i = 0; i < len * 8; i++) begin
                logic [7:0] b;
                b = pat(ADDR_W'(base + ADDR_W'(i / 8)));
                if (rec[i] !== b[7 - (i % 8)]) mism++;
            end
            chk(mism == 0, "R3 bit stream msb first", mism, 0);
            chk(req_log[restart_idx % 2048] == base, "R4 restart at frame base",
                int'(req_log[restart_idx % 2048]), int'(base));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && txd_o && !txd_en_o, "R1 idle line", int'(txd_o), 1);
        chk(!rd_req_o && !err_o && !irq_o && !done_o, "R1 flags low", int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && txd_o && !rd_req_o, "R1 after release", int'(busy_o), 0);
        for (int len = 1; len <= 7; len++) begin
            run_frame(len, -1, -1);
            for (int k = 0; k < len; k++) run_frame(len, k, -1);
        end
        run_frame(6, 1, 3);
        run_frame(7, 0, 2);
        run_frame(7, 3, 5);
        err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
        @(negedge clk);
        chk(!err_o, "R7 error cleared", int'(err_o), 0);
        begin
            int irq0;
            irq0 = irq_cnt;
            ind_pulse(1'b1);
            ind_pulse(1'b0);
            repeat (3) @(negedge clk);
            chk(!busy_o && !err_o && irq_cnt == irq0, "R7 idle ignores strobes",
                int'(busy_o), 0);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule